// File: doc/BRIEF.md
# CRC-8 Framed Packet Receiver

This block sits behind a UART on a host link and turns the stream of received bytes into checked packets. It looks for a start delimiter and reads a length byte, a control byte, a variable number of payload bytes, a CRC-8 byte and an end delimiter. The length byte counts the control byte, the payload bytes and the CRC byte. Payload bytes go into a local buffer as they arrive, and the control byte and payload count are presented once the whole frame has been checked.

Every complete or aborted frame is answered with a reply frame on a byte output, one byte per clock. A good frame is acknowledged: the reply echoes the received control byte. A bad frame is refused: the reply carries control byte 0x00 and a one-byte error number that says what went wrong. Reply frames use the same delimiters and carry their own CRC-8. The receiver assumes that received bytes arrive at least 8 clock cycles apart, which any UART rate far below the clock rate gives, so that a reply always ends before the next byte comes in.

Top module: `pkt_frame_rx`

## Requirements
- R1: After a synchronous active-high reset, pkt_valid and rep_valid are 0, pkt_ctrl is 0x00 and pkt_count is 0.
- R2: A frame is 0x7E, length L, control, L-2 payload bytes, CRC, 0x7F; the receiver takes L-2 payload bytes and then exactly one CRC byte and one end byte.
- R3: The CRC is CRC-8 with polynomial x^8+x^5+x^4+1 (0x31), start value 0x00, most significant bit first, no final inversion, taken over the control byte followed by the payload bytes.
- R4: For a good frame, pkt_valid is high for one cycle, one cycle after the clock edge that takes the end byte; pkt_ctrl and pkt_count then hold the control byte and payload count until the next good frame, and payload byte i reads back on rd_data for rd_addr = i.
- R5: A good frame is answered with the five bytes 0x7E, 0x02, control, CRC of the control byte, 0x7F on consecutive cycles, the first one cycle after pkt_valid.
- R6: A refusal is the six bytes 0x7E, 0x03, 0x00, error number, CRC over 0x00 and the error number, 0x7F on consecutive cycles, the first two cycles after the edge that takes the offending byte.
- R7: A length byte below 2 or above 34 is refused at once with error number 0x02; later bytes are ignored until the next 0x7E.
- R8: A CRC byte that differs from the computed CRC gives a refusal with error number 0x03 after the end byte, also when the end byte is wrong too, and leaves pkt_ctrl and pkt_count unchanged.
- R9: An end byte other than 0x7F after a correct CRC gives a refusal with error number 0x04 and no pkt_valid.
- R10: A byte taken while fifo_ovf is high inside a frame aborts the frame with error number 0x01 and a return to searching; fifo_ovf has no effect on a byte taken while searching for a start delimiter.
- R11: Bytes other than 0x7E between frames produce no reply and no pkt_valid.
- R12: Frames with no payload (L = 2) and with a full 32-byte payload (L = 34) are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| fifo_ovf | input | 1 | Receive FIFO has lost data; qualifies the byte taken with it |
| pkt_valid | output | 1 | One-cycle pulse: a good frame has been taken |
| pkt_ctrl | output | 8 | Control byte of the last good frame |
| pkt_count | output | 6 | Payload byte count of the last good frame |
| rd_addr | input | 5 | Payload buffer read address |
| rd_data | output | 8 | Payload byte at rd_addr |
| rep_valid | output | 1 | A reply byte is present this cycle |
| rep_byte | output | 8 | Reply byte |

## Verification
The receiver produces two kinds of result after the edge that takes a frame's deciding byte: pkt_valid one cycle later and reply byte i one plus i cycles after pkt_valid, so a refusal starts two cycles after its deciding byte. The bench stamps every rising edge with a cycle number, records the stamp of each observed pkt_valid and reply byte on the falling edge, and compares those stamps with the stamp of the edge that took the last byte it drove. Because bytes are driven 10 cycles apart, each reply is complete before the next stimulus and is compared byte for byte against a frame computed in the bench with its own bit-serial CRC. Sweeps cover every payload length from 0 to 32, every illegal length value, every single-bit CRC error, every wrong end byte and an overflow flag on each byte position of a frame.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

    localparam logic [7:0] HDR_BYTE  = 8'h7E;
    localparam logic [7:0] END_BYTE  = 8'h7F;
    localparam logic [7:0] CRC_POLY  = 8'h31;
    localparam logic [7:0] CRC_INIT  = 8'h00;
    localparam logic [7:0] NAK_CTRL  = 8'h00;
    localparam logic [7:0] LEN_MIN   = 8'd2;

    localparam logic [7:0] ERR_OVF   = 8'h01;
    localparam logic [7:0] ERR_LEN   = 8'h02;
    localparam logic [7:0] ERR_CRC   = 8'h03;
    localparam logic [7:0] ERR_END   = 8'h04;

    localparam logic [7:0] ACK_LEN   = 8'd2;
    localparam logic [7:0] NAK_LEN   = 8'd3;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_CTRL,
        ST_DATA,
        ST_CRC,
        ST_END
    } rx_state_e;

    typedef struct packed {
        logic       ack;
        logic [7:0] ctrl;
        logic [7:0] err;
    } reply_req_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] data);
        logic [7:0] c;
        c = crc_in ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_rx_fsm.sv
module pkt_rx_fsm
    import pkt_frame_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              fifo_ovf,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              req_valid,
    output reply_req_t        req,
    output logic              acc_valid,
    output logic [7:0]        acc_ctrl,
    output logic [CNT_W-1:0]  acc_count
);

    localparam logic [7:0] LEN_MAX = 8'(DEPTH + 2);

    rx_state_e        state;
    logic [CNT_W-1:0] ndata;
    logic [CNT_W-1:0] idx;
    logic [7:0]       crc;
    logic [7:0]       ctrl;
    logic             crc_ok;
    logic             abort;

    assign abort   = in_valid && fifo_ovf && (state != ST_HUNT);
    assign wr_en   = in_valid && !fifo_ovf && (state == ST_DATA);
    assign wr_addr = idx[ADDR_W-1:0];
    assign wr_data = in_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            ndata     <= '0;
            idx       <= '0;
            crc       <= CRC_INIT;
            ctrl      <= '0;
            crc_ok    <= 1'b0;
            req_valid <= 1'b0;
            req       <= '0;
            acc_valid <= 1'b0;
            acc_ctrl  <= '0;
            acc_count <= '0;
        end else begin
            req_valid <= 1'b0;
            acc_valid <= 1'b0;
            if (abort) begin
                req_valid <= 1'b1;
                req       <= '{ack: 1'b0, ctrl: NAK_CTRL, err: ERR_OVF};
                state     <= ST_HUNT;
            end else if (in_valid) begin
                case (state)
                    ST_HUNT: begin
                        if (in_byte == HDR_BYTE) state <= ST_LEN;
                    end
                    ST_LEN: begin
                        if (in_byte < LEN_MIN || in_byte > LEN_MAX) begin
                            req_valid <= 1'b1;
                            req       <= '{ack: 1'b0, ctrl: NAK_CTRL, err: ERR_LEN};
                            state     <= ST_HUNT;
                        end else begin
                            ndata <= CNT_W'(in_byte - LEN_MIN);
                            state <= ST_CTRL;
                        end
                    end
                    ST_CTRL: begin
                        ctrl  <= in_byte;
                        crc   <= crc8_step(CRC_INIT, in_byte);
                        idx   <= '0;
                        state <= (ndata == '0) ? ST_CRC : ST_DATA;
                    end
                    ST_DATA: begin
                        crc <= crc8_step(crc, in_byte);
                        idx <= idx + CNT_W'(1);
                        if ((idx + CNT_W'(1)) == ndata) state <= ST_CRC;
                    end
                    ST_CRC: begin
                        crc_ok <= (in_byte == crc);
                        state  <= ST_END;
                    end
                    ST_END: begin
                        state     <= ST_HUNT;
                        req_valid <= 1'b1;
                        if (!crc_ok) begin
                            req <= '{ack: 1'b0, ctrl: NAK_CTRL, err: ERR_CRC};
                        end else if (in_byte != END_BYTE) begin
                            req <= '{ack: 1'b0, ctrl: NAK_CTRL, err: ERR_END};
                        end else begin
                            req       <= '{ack: 1'b1, ctrl: ctrl, err: 8'h00};
                            acc_valid <= 1'b1;
                            acc_ctrl  <= ctrl;
                            acc_count <= ndata;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // Overflow inside a frame returns to searching and requests error 01.
    assert_ovf_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fifo_ovf && state != ST_HUNT) |=>
        (state == ST_HUNT && req_valid && !req.ack && req.err == ERR_OVF));

    // Acceptance only follows an end delimiter taken in the end state.
    assert_accept_end_R4: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ($past(in_valid) && $past(in_byte) == END_BYTE
                       && $past(state) == ST_END));

    // Payload writes never pass the announced count.
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (idx < ndata));

    // A length that was let through fits the buffer.
    assert_len_window_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CTRL) |-> (ndata <= CNT_W'(DEPTH)));

endmodule

// File: rtl/pkt_payload_buf.sv
module pkt_payload_buf #(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pkt_reply_gen.sv
module pkt_reply_gen
    import pkt_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  reply_req_t req,
    output logic       rep_valid,
    output logic [7:0] rep_byte
);

    logic       active;
    logic [2:0] idx;
    reply_req_t held;
    logic [7:0] crc_r;
    logic [2:0] last_idx;

    assign last_idx  = held.ack ? 3'd4 : 3'd5;
    assign rep_valid = active;

    always_comb begin
        case (idx)
            3'd0:    rep_byte = HDR_BYTE;
            3'd1:    rep_byte = held.ack ? ACK_LEN : NAK_LEN;
            3'd2:    rep_byte = held.ack ? held.ctrl : NAK_CTRL;
            3'd3:    rep_byte = held.ack ? crc_r : held.err;
            3'd4:    rep_byte = held.ack ? END_BYTE : crc_r;
            default: rep_byte = END_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            held   <= '0;
            crc_r  <= '0;
        end else if (req_valid) begin
            active <= 1'b1;
            idx    <= '0;
            held   <= req;
            crc_r  <= req.ack ? crc8_step(CRC_INIT, req.ctrl)
                              : crc8_step(crc8_step(CRC_INIT, NAK_CTRL), req.err);
        end else if (active) begin
            if (idx == last_idx) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 3'd1;
            end
        end
    end

    // A new reply never cuts into one still being sent.
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !active);

endmodule

// File: rtl/pkt_frame_rx.sv
module pkt_frame_rx
    import pkt_frame_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              fifo_ovf,
    output logic              pkt_valid,
    output logic [7:0]        pkt_ctrl,
    output logic [CNT_W-1:0]  pkt_count,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rep_valid,
    output logic [7:0]        rep_byte
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              req_valid;
    reply_req_t        req;

    pkt_rx_fsm #(.DEPTH(DEPTH)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .fifo_ovf  (fifo_ovf),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .req_valid (req_valid),
        .req       (req),
        .acc_valid (pkt_valid),
        .acc_ctrl  (pkt_ctrl),
        .acc_count (pkt_count)
    );

    pkt_payload_buf #(.DEPTH(DEPTH)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pkt_reply_gen gen_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .rep_valid (rep_valid),
        .rep_byte  (rep_byte)
    );

    // An accepted frame is followed next cycle by the start of its reply.
    assert_ack_follows_R5: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> (rep_valid && rep_byte == HDR_BYTE));

endmodule

// File: tb/pkt_frame_rx_tb_top.sv
module pkt_frame_rx_tb_top;

    localparam int DEPTH  = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic              fifo_ovf = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              pkt_valid;
    logic [7:0]        pkt_ctrl;
    logic [CNT_W-1:0]  pkt_count;
    logic [7:0]        rd_data;
    logic              rep_valid;
    logic [7:0]        rep_byte;

    pkt_frame_rx #(.DEPTH(DEPTH)) dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_byte (in_byte),
        .fifo_ovf (fifo_ovf), .pkt_valid (pkt_valid), .pkt_ctrl (pkt_ctrl),
        .pkt_count (pkt_count), .rd_addr (rd_addr), .rd_data (rd_data),
        .rep_valid (rep_valid), .rep_byte (rep_byte)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    int pv_cnt = 0;
    int pv_cyc = 0;
    int t_last = 0;
    int exp_pv = 0;
    logic [7:0] rq[$];
    int         rc[$];
    logic [7:0] fr [0:39];
    int         fl = 0;
    logic [7:0] ex [0:5];
    int         exn = 0;

    always @(negedge clk) begin
        if (rep_valid) begin
            rq.push_back(rep_byte);
            rc.push_back(cyc);
        end
        if (pkt_valid) begin
            pv_cnt++;
            pv_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bit-serial reference CRC, one message bit at a time.
    function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] b);
        logic [7:0] c;
        logic fb;
        c = c_in;
        for (int k = 7; k >= 0; k--) begin
            fb = c[7] ^ b[k];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h31 : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 29 + 5) & 255);
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit ovf);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        fifo_ovf = ovf;
        @(negedge clk);
        in_valid = 1'b0;
        fifo_ovf = 1'b0;
        t_last   = cyc;
        repeat (8) @(negedge clk);
    endtask

    task automatic build(input logic [7:0] ctrl, input int n, input int seed,
                         input logic [7:0] crc_flip, input logic [7:0] tail);
        logic [7:0] c;
        fr[0] = 8'h7E;
        fr[1] = 8'(n + 2);
        fr[2] = ctrl;
        c = ref_crc(8'h00, ctrl);
        for (int i = 0; i < n; i++) begin
            fr[3 + i] = pat(seed, i);
            c = ref_crc(c, pat(seed, i));
        end
        fr[3 + n] = c ^ crc_flip;
        fr[4 + n] = tail;
        fl = n + 5;
    endtask

    task automatic send_frame(input int ovf_at);
        bit stop;
        stop = 1'b0;
        for (int i = 0; i < fl; i++) begin
            if (!stop) begin
                send_byte(fr[i], i == ovf_at);
                if (i == ovf_at) stop = 1'b1;
            end
        end
    endtask

    task automatic expect_reply(input string tag, input bit ack,
                                input logic [7:0] ctrl, input logic [7:0] err);
        if (ack) begin
            ex[0] = 8'h7E; ex[1] = 8'h02; ex[2] = ctrl;
            ex[3] = ref_crc(8'h00, ctrl); ex[4] = 8'h7F; exn = 5;
        end else begin
            ex[0] = 8'h7E; ex[1] = 8'h03; ex[2] = 8'h00; ex[3] = err;
            ex[4] = ref_crc(ref_crc(8'h00, 8'h00), err); ex[5] = 8'h7F; exn = 6;
        end
        chk(rq.size() == exn, {tag, " reply length"}, rq.size(), exn);
        for (int i = 0; i < exn; i++) begin
            if (i < rq.size()) begin
                chk(rq[i] == ex[i], {tag, " reply byte"}, rq[i], ex[i]);
                chk(rc[i] == t_last + 1 + i, {tag, " reply cycle"}, rc[i], t_last + 1 + i);
            end
        end
        if (ack) chk(pv_cyc == t_last, {tag, " pkt_valid cycle"}, pv_cyc, t_last);
        chk(pv_cnt == exp_pv, {tag, " pkt_valid count"}, pv_cnt, exp_pv);
        rq.delete();
        rc.delete();
    endtask

    task automatic expect_silence(input string tag);
        chk(rq.size() == 0, {tag, " unexpected reply"}, rq.size(), 0);
        chk(pv_cnt == exp_pv, {tag, " pkt_valid count"}, pv_cnt, exp_pv);
        rq.delete();
        rc.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(pkt_valid == 1'b0, "R1 pkt_valid", pkt_valid, 0);
        chk(rep_valid == 1'b0, "R1 rep_valid", rep_valid, 0);
        chk(pkt_ctrl == 8'h00, "R1 pkt_ctrl", pkt_ctrl, 0);
        chk(pkt_count == '0, "R1 pkt_count", pkt_count, 0);

        // R11: stray bytes while searching
        send_byte(8'h00, 1'b0);
        send_byte(8'h7F, 1'b0);
        send_byte(8'h55, 1'b0);
        send_byte(8'hA3, 1'b1);
        expect_silence("R11 stray");

        // R2 R3 R4 R5 R12: every payload length
        for (int n = 0; n <= DEPTH; n++) begin
            build(8'(8'h40 + n), n, n, 8'h00, 8'h7F);
            send_frame(-1);
            exp_pv++;
            expect_reply("R5 ack", 1'b1, 8'(8'h40 + n), 8'h00);
            chk(pkt_ctrl == 8'(8'h40 + n), "R4 ctrl", pkt_ctrl, 8'h40 + n);
            chk(int'(pkt_count) == n, "R2 count", pkt_count, n);
            for (int i = 0; i < n; i++) begin
                rd_addr = ADDR_W'(i);
                #1;
                chk(rd_data == pat(n, i), "R4 payload", rd_data, pat(n, i));
            end
            if (n == 0 || n == DEPTH) chk(pkt_count == CNT_W'(n), "R12 bound", pkt_count, n);
        end

        // R7: every illegal length value
        for (int len = 0; len < 256; len++) begin
            if (len < 2 || len > DEPTH + 2) begin
                send_byte(8'h7E, 1'b0);
                send_byte(8'(len), 1'b0);
                expect_reply("R7 length", 1'b0, 8'h00, 8'h02);
                send_byte(8'h11, 1'b0);
                expect_silence("R7 resync");
            end
        end
        chk(pkt_ctrl == 8'h60, "R7 ctrl kept", pkt_ctrl, 8'h60);

        // R3 R8: every single-bit CRC error
        for (int b = 0; b < 8; b++) begin
            build(8'h5A, 3, 7, 8'(1 << b), 8'h7F);
            send_frame(-1);
            expect_reply("R8 crc", 1'b0, 8'h00, 8'h03);
        end
        build(8'h5A, 3, 7, 8'h01, 8'h00);
        send_frame(-1);
        expect_reply("R8 crc before end", 1'b0, 8'h00, 8'h03);
        chk(pkt_ctrl == 8'h60, "R8 ctrl kept", pkt_ctrl, 8'h60);
        chk(int'(pkt_count) == DEPTH, "R8 count kept", pkt_count, DEPTH);

        // R9: every wrong end byte
        for (int t = 0; t < 256; t++) begin
            if (t != 8'h7F) begin
                build(8'h33, 0, 0, 8'h00, 8'(t));
                send_frame(-1);
                expect_reply("R9 end", 1'b0, 8'h00, 8'h04);
            end
        end
        chk(pkt_ctrl == 8'h60, "R9 ctrl kept", pkt_ctrl, 8'h60);

        // R10: overflow on each position inside a frame, then recovery
        for (int p = 1; p < 7; p++) begin
            build(8'h21, 2, 3, 8'h00, 8'h7F);
            send_frame(p);
            expect_reply("R10 overflow", 1'b0, 8'h00, 8'h01);
            build(8'h22, 1, p, 8'h00, 8'h7F);
            send_frame(-1);
            exp_pv++;
            expect_reply("R10 recovery", 1'b1, 8'h22, 8'h00);
        end
        // R10: flag on the start delimiter has no effect
        build(8'h23, 2, 9, 8'h00, 8'h7F);
        send_frame(0);
        for (int i = 1; i < fl; i++) send_byte(fr[i], 1'b0);
        exp_pv++;
        expect_reply("R10 searching", 1'b1, 8'h23, 8'h00);
        chk(int'(pkt_count) == 2, "R10 count", pkt_count, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule